// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block is one memory-mapped digital I/O port of parameterised width (eight pins by default). Software reaches it over a simple register bus. Three register locations sit behind the bus:

- a drive-value register;
- a direction register;
- a read-only view of the pad levels.

Each pin presents to its pad cell a drive value, an output enable and a pull-up enable. Each pin receives back the pad level, which is retimed through a two-flop synchronizer before software can see it.

Two operations let software change a single pin without a read-modify-write sequence, so no other pin is disturbed:

- Writing ones to the pad-level location inverts the matching drive-value bits.
- A bit-set or bit-clear command, carrying a register select and a bit index, changes exactly one bit of the selected register in one cycle.

For a pin set as input, its drive-value bit requests the pull-up. A chip-wide pull-up kill input overrides every such request.

Top module: `gpio_port_bank`

## Requirements
- R1: While reset is asserted, and after it is released, the drive-value and direction registers are zero. So `pin_oe`, `pin_out` and `pin_pu` are all zero and the data and direction registers read back as zero.
- R2: A bus write to select 0 (drive value) or select 1 (direction) stores `bus_wdata` into that register at the clock edge. A later read at the same select returns it.
- R3: A bus write to select 2 (pad levels) inverts each drive-value bit whose `bus_wdata` bit is one. It leaves the bits whose `bus_wdata` bit is zero unchanged, and it does not change the direction register.
- R4: A read at select 2 returns the pad level presented two rising clock edges earlier, whatever the direction bits hold.
- R5: A bit-set command at select 0 or 1 sets bit `bus_bidx` of that register and changes no other bit of either register.
- R6: A bit-clear command at select 0 or 1 clears bit `bus_bidx` of that register and changes no other bit of either register.
- R7: A bit-set command at select 2 inverts drive-value bit `bus_bidx` only. A bit-clear command at select 2 changes nothing.
- R8: `pin_oe` equals the direction register and `pin_out` equals the drive-value register, bit for bit.
- R9: `pin_pu[n]` is one exactly when direction bit n is zero, drive-value bit n is one, and `pud_all` is zero.
- R10: Only one command acts per cycle, with full write over bit-set over bit-clear. Select 3 holds no register: writes and bit commands there are ignored and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 2 | Register select: 0 drive value, 1 direction, 2 pad levels, 3 unused |
| bus_wr | input | 1 | Full-register write strobe |
| bus_wdata | input | PORT_W | Write data |
| bus_bset | input | 1 | Single-bit set command |
| bus_bclr | input | 1 | Single-bit clear command |
| bus_bidx | input | $clog2(PORT_W) | Bit index for set and clear commands |
| bus_rdata | output | PORT_W | Read data for the selected register (combinational) |
| pud_all | input | 1 | Chip-wide pull-up disable |
| pin_pad | input | PORT_W | Pad levels, asynchronous to clk |
| pin_out | output | PORT_W | Drive value per pin |
| pin_oe | output | PORT_W | Output enable per pin |
| pin_pu | output | PORT_W | Pull-up enable per pin |

## Verification
The two functions that can fall in the same cycle are the synchronizer picking up a new pad level and a toggle write into the pad-level location. Both act on the same read location, but only the toggle may change stored state. The bench changes the pad levels and issues a toggle write at the same clock edge. Two edges later it judges that the read at select 2 shows the new pad levels, and that the drive value shows exactly the toggled pattern. A second collision, a full write together with bit-set and bit-clear commands on the same register, is judged against the stated priority.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PINS = 2'd2,
    SEL_NONE = 2'd3
  } gpio_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  // Assertion is immediate; release is retimed through two flops.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  gpio_sel_e     sel,
  input  logic          wr,
  input  logic          bset,
  input  logic          bclr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] bidx,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  dir_q
);
  logic [W-1:0] bmask;
  logic [W-1:0] out_d, dir_d;
  logic         out_en, dir_en;

  // Next-state: one command per cycle, write > set > clear.
  always_comb begin
    bmask  = {{(W-1){1'b0}}, 1'b1} << bidx;
    out_d  = out_q;
    dir_d  = dir_q;
    out_en = 1'b0;
    dir_en = 1'b0;
    if (wr) begin
      unique case (sel)
        SEL_DATA: begin out_d = wdata;          out_en = 1'b1; end
        SEL_DIR:  begin dir_d = wdata;          dir_en = 1'b1; end
        SEL_PINS: begin out_d = out_q ^ wdata;  out_en = 1'b1; end
        default: ;
      endcase
    end else if (bset) begin
      unique case (sel)
        SEL_DATA: begin out_d = out_q | bmask;  out_en = 1'b1; end
        SEL_DIR:  begin dir_d = dir_q | bmask;  dir_en = 1'b1; end
        SEL_PINS: begin out_d = out_q ^ bmask;  out_en = 1'b1; end
        default: ;
      endcase
    end else if (bclr) begin
      unique case (sel)
        SEL_DATA: begin out_d = out_q & ~bmask; out_en = 1'b1; end
        SEL_DIR:  begin dir_d = dir_q & ~bmask; dir_en = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (out_en) out_q <= out_d;
      if (dir_en) dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] dir_q,
  input  logic         pud_all,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pu
);
  for (genvar n = 0; n < W; n++) begin : g_pin
    always_comb begin
      pin_out[n] = out_q[n];
      pin_oe[n]  = dir_q[n];
      pin_pu[n]  = ~dir_q[n] & out_q[n] & ~pud_all;
    end
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_pkg::*;
#(
  parameter int unsigned PORT_W = 8,
  localparam int unsigned IDX_W = (PORT_W > 1) ? $clog2(PORT_W) : 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [1:0]        bus_sel,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic              bus_bset,
  input  logic              bus_bclr,
  input  logic [IDX_W-1:0]  bus_bidx,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic              pud_all,
  input  logic [PORT_W-1:0] pin_pad,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_pu
);
  logic              rst_n;
  gpio_sel_e         sel;
  logic [PORT_W-1:0] out_q, dir_q, pad_sync;

  assign sel = gpio_sel_e'(bus_sel);

  gpio_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  gpio_sync #(.W(PORT_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_pad),
    .sync_o  (pad_sync)
  );

  gpio_regs #(.W(PORT_W), .IW(IDX_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .wr    (bus_wr),
    .bset  (bus_bset),
    .bclr  (bus_bclr),
    .wdata (bus_wdata),
    .bidx  (bus_bidx),
    .out_q (out_q),
    .dir_q (dir_q)
  );

  gpio_pad_ctrl #(.W(PORT_W)) u_pad (
    .out_q   (out_q),
    .dir_q   (dir_q),
    .pud_all (pud_all),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pin_pu  (pin_pu)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: bus_rdata = out_q;
      SEL_DIR:  bus_rdata = dir_q;
      SEL_PINS: bus_rdata = pad_sync;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_sel,
  input logic              bus_wr,
  input logic [PORT_W-1:0] bus_wdata,
  input logic              bus_bset,
  input logic              bus_bclr,
  input logic [IDX_W-1:0]  bus_bidx,
  input logic [PORT_W-1:0] bus_rdata,
  input logic              pud_all,
  input logic [PORT_W-1:0] pin_pad,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] pin_pu
);
  logic [1:0]        age_q;
  logic [PORT_W-1:0] one_hot;

  assign one_hot = {{(PORT_W-1){1'b0}}, 1'b1} << bus_bidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  AST_WR_DATA_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd0) |=> pin_out == $past(bus_wdata)); // R2
  AST_WR_DIR_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd1) |=> pin_oe == $past(bus_wdata)); // R8
  AST_PIN_WR_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd2) |=> (pin_out == ($past(pin_out) ^ $past(bus_wdata))) && $stable(pin_oe)); // R3
  AST_PAD_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && bus_sel == 2'd2) |-> bus_rdata == $past(pin_pad, 2)); // R4
  AST_BSET_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && bus_bset && bus_sel == 2'd0) |=> (pin_out == ($past(pin_out) | $past(one_hot))) && $stable(pin_oe)); // R5
  AST_BCLR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_bset && bus_bclr && bus_sel == 2'd1) |=> (pin_oe == ($past(pin_oe) & ~$past(one_hot))) && $stable(pin_out)); // R6
  AST_PU_KILLED: assert property (@(posedge clk) disable iff (!rst_n)
    pud_all |-> pin_pu == '0); // R9
  AST_PU_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_bset && !bus_bclr) |=> $stable(pin_out) && $stable(pin_oe)); // R10
  AST_HOLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == 2'd3) |=> $stable(pin_out) && $stable(pin_oe)); // R10
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.PORT_W(PORT_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_bset  (bus_bset),
  .bus_bclr  (bus_bclr),
  .bus_bidx  (bus_bidx),
  .bus_rdata (bus_rdata),
  .pud_all   (pud_all),
  .pin_pad   (pin_pad),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_pu    (pin_pu)
);

// File: tb/gpio_port_bank_tb.sv
`timescale 1ns/1ps
module gpio_port_bank_tb;
  localparam int W  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [1:0]    bus_sel;
  logic          bus_wr, bus_bset, bus_bclr, pud_all;
  logic [W-1:0]  bus_wdata, pin_pad;
  logic [IW-1:0] bus_bidx;
  logic [W-1:0]  bus_rdata, pin_out, pin_oe, pin_pu;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  gpio_port_bank #(.PORT_W(W)) u_dut (
    .clk(clk), .rst_ni(rst_ni), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_bset(bus_bset), .bus_bclr(bus_bclr),
    .bus_bidx(bus_bidx), .bus_rdata(bus_rdata), .pud_all(pud_all),
    .pin_pad(pin_pad), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Issue one command for a single clock edge; return at the following negedge.
  task automatic cmd(input logic [1:0] s, input logic w, input logic bs, input logic bc,
                     input logic [W-1:0] d, input logic [IW-1:0] ix);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_bset = bs; bus_bclr = bc; bus_wdata = d; bus_bidx = ix;
    @(negedge clk);
    bus_wr = 1'b0; bus_bset = 1'b0; bus_bclr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [W-1:0] v);
    bus_sel = s;
    #0.5;
    v = bus_rdata;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "oe in reset", pin_oe, '0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "oe", pin_oe, '0);
    chk("R1", "out", pin_out, '0);
    chk("R1", "pu", pin_pu, '0);
    rd(2'd0, v); chk("R1", "data read", v, '0);
    rd(2'd1, v); chk("R1", "dir read", v, '0);
  endtask

  task automatic t_full_write;
    logic [W-1:0] v;
    cmd(2'd0, 1, 0, 0, 8'hA5, 0);
    rd(2'd0, v); chk("R2", "data readback", v, 8'hA5);
    chk("R8", "pin_out", pin_out, 8'hA5);
    cmd(2'd1, 1, 0, 0, 8'h3C, 0);
    rd(2'd1, v); chk("R2", "dir readback", v, 8'h3C);
    chk("R8", "pin_oe", pin_oe, 8'h3C);
    chk("R9", "pu pattern", pin_pu, 8'h81);
  endtask

  task automatic t_toggle;
    cmd(2'd2, 1, 0, 0, 8'h0F, 0);
    chk("R3", "toggled out", pin_out, 8'hAA);
    chk("R3", "dir untouched", pin_oe, 8'h3C);
    cmd(2'd2, 1, 0, 0, 8'h00, 0);
    chk("R3", "zero write no change", pin_out, 8'hAA);
  endtask

  task automatic t_pad_sync;
    logic [W-1:0] v;
    @(negedge clk); pin_pad = 8'h5E; bus_sel = 2'd2;
    @(negedge clk); rd(2'd2, v); chk("R4", "one edge not yet", v, 8'h00);
    @(negedge clk); rd(2'd2, v); chk("R4", "two edges", v, 8'h5E);
    chk("R4", "dir irrelevant", pin_oe, 8'h3C);
  endtask

  task automatic t_bit_set_clr;
    cmd(2'd1, 1, 0, 0, 8'h00, 0);
    cmd(2'd0, 1, 0, 0, 8'h00, 0);
    cmd(2'd0, 0, 1, 0, 8'hFF, 3'd6);
    chk("R5", "set data bit6", pin_out, 8'h40);
    chk("R5", "dir untouched", pin_oe, 8'h00);
    cmd(2'd1, 0, 1, 0, 8'h00, 3'd1);
    chk("R5", "set dir bit1", pin_oe, 8'h02);
    cmd(2'd0, 1, 0, 0, 8'hFF, 0);
    cmd(2'd0, 0, 0, 1, 8'h00, 3'd7);
    chk("R6", "clr data bit7", pin_out, 8'h7F);
    cmd(2'd1, 0, 0, 1, 8'hFF, 3'd1);
    chk("R6", "clr dir bit1", pin_oe, 8'h00);
    chk("R6", "data untouched", pin_out, 8'h7F);
  endtask

  task automatic t_pin_bitops;
    cmd(2'd2, 0, 1, 0, 8'h00, 3'd0);
    chk("R7", "bit-set on pins toggles", pin_out, 8'h7E);
    cmd(2'd2, 0, 0, 1, 8'h00, 3'd2);
    chk("R7", "bit-clr on pins ignored", pin_out, 8'h7E);
  endtask

  task automatic t_pullup;
    cmd(2'd1, 1, 0, 0, 8'h0F, 0);
    chk("R9", "pu inputs only", pin_pu, 8'h70);
    @(negedge clk); pud_all = 1'b1; #0.5;
    chk("R9", "pu killed", pin_pu, 8'h00);
    @(negedge clk); pud_all = 1'b0; #0.5;
    chk("R9", "pu restored", pin_pu, 8'h70);
  endtask

  task automatic t_priority_hole;
    logic [W-1:0] v;
    cmd(2'd0, 1, 1, 1, 8'hF0, 3'd0);
    chk("R10", "write beats set", pin_out, 8'hF0);
    cmd(2'd0, 0, 1, 1, 8'h00, 3'd2);
    chk("R10", "set beats clear", pin_out, 8'hF4);
    cmd(2'd3, 1, 0, 0, 8'h99, 0);
    cmd(2'd3, 0, 1, 0, 8'h00, 3'd0);
    chk("R10", "hole: data held", pin_out, 8'hF4);
    chk("R10", "hole: dir held", pin_oe, 8'h0F);
    rd(2'd3, v); chk("R10", "hole reads zero", v, 8'h00);
  endtask

  // Pad change and toggle write at the same edge.
  task automatic t_collision;
    logic [W-1:0] v;
    @(negedge clk);
    pin_pad = 8'hC3; bus_sel = 2'd2; bus_wr = 1'b1; bus_wdata = 8'hFF;
    @(negedge clk); bus_wr = 1'b0;
    chk("R3", "collision toggle", pin_out, 8'h0B);
    @(negedge clk); rd(2'd2, v); chk("R4", "collision pad", v, 8'hC3);
  endtask

  initial begin
    rst_ni = 1'b0; bus_sel = 2'd0; bus_wr = 0; bus_bset = 0; bus_bclr = 0;
    bus_wdata = '0; bus_bidx = '0; pud_all = 0; pin_pad = '0;
    t_reset();
    t_full_write();
    t_toggle();
    t_pad_sync();
    t_bit_set_clr();
    t_pin_bitops();
    t_pullup();
    t_priority_hole();
    t_collision();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule